// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Router

This block turns a memory-mapped access into a configuration-space access on a single bus. The access offset is itself the configuration address: it is split into bus, device, function and dword-register fields on every request, with no enable bit and no latched address. Routing depends only on the current request, so each access stands alone.

Device 0 on bus 0 is a small host-bridge register file held inside the block. Devices 1 and up select external slots. Each slot gets a one-hot request strobe, the register and function numbers, a byte-enable mask and lane-aligned write data, and it returns its dword in the same cycle. Accesses are 1, 2 or 4 bytes wide. Any request that cannot be routed reads as all ones and writes nothing. This covers offsets above the 32-bit range, bus numbers other than zero, reads or writes that cross a dword boundary, illegal sizes and missing slots. A read response is registered and appears one cycle after the request.

Top module: `cfg_window_router`

## Requirements
- R1: The offset is decoded as bus = bits 23:16, device = bits 15:11, function = bits 10:8, dword register = bits 7:2 and start lane = bits 1:0. The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes; code 3 is illegal. Bits 31:24 are ignored, and the host bridge ignores the function field.
- R2: If any offset bit at position 32 or above is set, a read returns 32'hFFFF_FFFF, a write changes no register, and no slot strobe is raised.
- R3: A read whose start lane plus length exceeds 4, or whose size code is 3, returns 32'hFFFF_FFFF.
- R4: A bus number other than 0 makes a read return 32'hFFFF_FFFF, and a write has no effect on any register or slot.
- R5: A read of device 0 returns the addressed host-bridge dword shifted right by 8 × start lane. Bytes above the access length read as zero.
- R6: A write to device 0 replaces only the bytes from the start lane up to start lane + length − 1, taking the low bytes of the write data. A write that crosses the dword boundary or uses size code 3 is discarded.
- R7: Register 0 always reads HB_ID and register 2 always reads HB_CLASS; writes to them are ignored. Registers at index HB_REGS and above read zero and ignore writes. All other host-bridge registers reset to zero.
- R8: Device N, for N from 1 to NUM_SLOTS, raises slotReq bit N−1 in the request cycle. In that cycle slotReg and slotFunc carry the decoded fields, slotBe carries the lane mask and slotWdata carries the write data shifted left by 8 × start lane. A read returns that slot's dword, shifted and masked as in R5.
- R9: A device above NUM_SLOTS, or a slot whose slotPresent bit is low, raises no strobe; a read of it returns 32'hFFFF_FFFF.
- R10: rspValid is high exactly one cycle after each read request, stays low after writes and idle cycles, and is low during reset with rspRdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access offset (configuration address) |
| reqSize | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| reqWdata | input | 32 | Write data, low bytes first |
| slotPresent | input | NUM_SLOTS | One bit per slot that is populated |
| slotRdata | input | NUM_SLOTS*32 | Dword from each slot, slot k at bits 32k+31:32k |
| slotReq | output | NUM_SLOTS | One-hot slot strobe |
| slotWrite | output | 1 | Strobed access is a write |
| slotFunc | output | 3 | Decoded function number |
| slotReg | output | 6 | Decoded dword register |
| slotBe | output | 4 | Byte-enable mask for the dword |
| slotWdata | output | 32 | Lane-aligned write data |
| rspValid | output | 1 | Read response valid |
| rspRdata | output | 32 | Read response data |

## Verification
The assertions assume that the request fields are stable and fully driven while reqValid is high. They also assume that each slot returns its dword combinationally from slotReg and slotFunc in the request cycle, and that slotPresent only changes while no request is pending. The stimulus meets these conditions. It drives every access on the falling clock edge, follows each one with an idle edge, and builds the slot models as pure functions of the decoded fields. The presence mask is fixed for the whole run.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  // Strobes passed from the decode control to the datapath
  typedef struct packed {
    logic hbWrite;     // accepted write to a host-bridge register
    logic hbRead;      // read data comes from the host bridge
    logic readEn;      // a read request is present this cycle
    logic readReject;  // the read must return all ones
  } winStrobes_t;

  // Byte mask of an access of the given size code, aligned to lane 0
  function automatic logic [3:0] sizeToMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic [NUM_SLOTS-1:0] slotPresent,
  output winStrobes_t          strobes,
  output logic [1:0]           lane,
  output logic [3:0]           sizeMask,
  output logic [3:0]           byteEn,
  output logic [5:0]           regIdx,
  output logic [2:0]           funcIdx,
  output logic [4:0]           slotNum,
  output logic [NUM_SLOTS-1:0] slotReq
);

  localparam int DEV_W = 5;

  logic [7:0]       busNum;
  logic [DEV_W-1:0] devNum;
  logic             highSet;
  logic [7:0]       spread;
  logic             fits;
  logic             routable;
  logic             isHb;
  logic             presentHit;
  logic [7:0]       unusedTop;

  assign busNum    = reqAddr[23:16];
  assign devNum    = reqAddr[15:11];
  assign funcIdx   = reqAddr[10:8];
  assign regIdx    = reqAddr[7:2];
  assign lane      = reqAddr[1:0];
  assign unusedTop = reqAddr[31:24];
  assign highSet   = |reqAddr[ADDR_W-1:32];

  assign sizeMask = sizeToMask(reqSize);
  assign spread   = {4'b0000, sizeMask} << lane;
  assign byteEn   = spread[3:0];
  assign fits     = (sizeMask != 4'b0000) && (spread[7:4] == 4'b0000);
  assign routable = !highSet && (busNum == 8'd0) && fits;
  assign isHb     = (devNum == '0);
  assign slotNum  = devNum - 5'd1;

  always_comb begin
    presentHit = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (devNum == DEV_W'(k + 1)) presentHit = slotPresent[k];
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slotReq
    assign slotReq[k] = reqValid && routable && (devNum == DEV_W'(k + 1)) && slotPresent[k];
  end

  assign strobes.hbWrite    = reqValid && reqWrite && routable && isHb;
  assign strobes.hbRead     = isHb;
  assign strobes.readEn     = reqValid && !reqWrite;
  assign strobes.readReject = !routable || (!isHb && !presentHit);

  // R8: at most one slot strobed at a time
  a_r8_slot_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slotReq));

  // R2: offsets beyond 32 bits reach no target
  a_r2_high_offset_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && highSet) |-> (slotReq == '0 && !strobes.hbWrite));

  // R4: other buses reach no target
  a_r4_other_bus_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && busNum != 8'd0) |-> (slotReq == '0 && !strobes.hbWrite));

  // R8: a strobed slot always sees at least one enabled byte
  a_r8_strobe_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (slotReq != '0) |-> (byteEn != 4'b0000));

endmodule

// File: rtl/cfgwin_datapath.sv
module cfgwin_datapath
  import cfgwin_pkg::*;
#(
  parameter int          NUM_SLOTS = 4,
  parameter int          HB_REGS   = 16,
  parameter logic [31:0] HB_ID     = 32'hC0DE_1234,
  parameter logic [31:0] HB_CLASS  = 32'h0600_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  winStrobes_t            strobes,
  input  logic [1:0]             lane,
  input  logic [3:0]             sizeMask,
  input  logic [3:0]             byteEn,
  input  logic [5:0]             regIdx,
  input  logic [4:0]             slotNum,
  input  logic [31:0]            reqWdata,
  input  logic [NUM_SLOTS*32-1:0] slotRdata,
  output logic [31:0]            laneWdata,
  output logic                   rspValid,
  output logic [31:0]            rspRdata
);

  localparam int ID_IDX    = 0;
  localparam int CLASS_IDX = 2;

  logic [HB_REGS*32-1:0] hbFlat;
  logic [31:0] hbVal;
  logic [31:0] slotVal;
  logic [31:0] shifted;
  logic [31:0] dataMask;
  logic [31:0] rspNext;

  assign laneWdata = reqWdata << {lane, 3'b000};

  for (genvar i = 0; i < HB_REGS; i++) begin : g_hbReg
    if (i == ID_IDX) begin : g_id
      assign hbFlat[i*32 +: 32] = HB_ID;
    end else if (i == CLASS_IDX) begin : g_class
      assign hbFlat[i*32 +: 32] = HB_CLASS;
    end else begin : g_rw
      logic [31:0] cellQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cellQ <= '0;
        end else if (strobes.hbWrite && regIdx == 6'(i)) begin
          for (int b = 0; b < 4; b++) begin
            if (byteEn[b]) cellQ[b*8 +: 8] <= laneWdata[b*8 +: 8];
          end
        end
      end
      assign hbFlat[i*32 +: 32] = cellQ;
    end
  end

  always_comb begin
    hbVal = '0;
    for (int k = 0; k < HB_REGS; k++) begin
      if (regIdx == 6'(k)) hbVal = hbFlat[k*32 +: 32];
    end
  end

  always_comb begin
    slotVal = '1;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slotNum == 5'(k)) slotVal = slotRdata[k*32 +: 32];
    end
  end

  assign shifted  = (strobes.hbRead ? hbVal : slotVal) >> {lane, 3'b000};
  assign dataMask = {{8{sizeMask[3]}}, {8{sizeMask[2]}}, {8{sizeMask[1]}}, {8{sizeMask[0]}}};
  assign rspNext  = strobes.readReject ? '1 : (shifted & dataMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobes.readEn;
      if (strobes.readEn) rspRdata <= rspNext;
    end
  end

  // R3: rejected reads answer all ones
  a_r3_reject_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.readEn && strobes.readReject) |=> (rspRdata == 32'hFFFF_FFFF));

  // R6: host-bridge registers hold when no write is accepted
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.hbWrite |=> $stable(hbFlat));

  // R5: single-byte reads clear the upper bytes
  a_r5_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.readEn && !strobes.readReject && sizeMask == 4'b0001) |=> (rspRdata[31:8] == 24'd0));

endmodule

// File: rtl/cfg_window_router.sv
module cfg_window_router
  import cfgwin_pkg::*;
#(
  parameter int          ADDR_W    = 40,
  parameter int          NUM_SLOTS = 4,
  parameter int          HB_REGS   = 16,
  parameter logic [31:0] HB_ID     = 32'hC0DE_1234,
  parameter logic [31:0] HB_CLASS  = 32'h0600_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic [31:0]             reqWdata,
  input  logic [NUM_SLOTS-1:0]    slotPresent,
  input  logic [NUM_SLOTS*32-1:0] slotRdata,
  output logic [NUM_SLOTS-1:0]    slotReq,
  output logic                    slotWrite,
  output logic [2:0]              slotFunc,
  output logic [5:0]              slotReg,
  output logic [3:0]              slotBe,
  output logic [31:0]             slotWdata,
  output logic                    rspValid,
  output logic [31:0]             rspRdata
);

  winStrobes_t strobes;
  logic [1:0]  lane;
  logic [3:0]  sizeMask;
  logic [4:0]  slotNum;

  assign slotWrite = reqWrite;

  cfgwin_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .slotPresent(slotPresent),
    .strobes    (strobes),
    .lane       (lane),
    .sizeMask   (sizeMask),
    .byteEn     (slotBe),
    .regIdx     (slotReg),
    .funcIdx    (slotFunc),
    .slotNum    (slotNum),
    .slotReq    (slotReq)
  );

  cfgwin_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .HB_REGS  (HB_REGS),
    .HB_ID    (HB_ID),
    .HB_CLASS (HB_CLASS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .lane     (lane),
    .sizeMask (sizeMask),
    .byteEn   (slotBe),
    .regIdx   (slotReg),
    .slotNum  (slotNum),
    .reqWdata (reqWdata),
    .slotRdata(slotRdata),
    .laneWdata(slotWdata),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

  // R10: every read request is answered on the next cycle
  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite) |=> rspValid);

  // R10: no response without a read request
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && !reqWrite) |=> !rspValid);

endmodule

// File: tb/cfg_window_router_tb.sv
module cfg_window_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 40;
  localparam int NUM_SLOTS  = 4;
  localparam int HB_REGS    = 16;
  localparam logic [31:0] HB_ID    = 32'hC0DE_1234;
  localparam logic [31:0] HB_CLASS = 32'h0600_0000;
  localparam logic [NUM_SLOTS-1:0] PRESENT = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [NUM_SLOTS-1:0] slotPresent = PRESENT;
  logic [NUM_SLOTS*32-1:0] slotRdata;
  logic [NUM_SLOTS-1:0] slotReq;
  logic slotWrite;
  logic [2:0] slotFunc;
  logic [5:0] slotReg;
  logic [3:0] slotBe;
  logic [31:0] slotWdata;
  logic rspValid;
  logic [31:0] rspRdata;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  logic [31:0] hbModel [64];
  logic [NUM_SLOTS-1:0] obsReq;
  logic [3:0] obsBe;
  logic [31:0] obsWd;
  logic [2:0] obsFunc;
  logic [5:0] obsReg;
  logic obsRv;
  logic [31:0] obsRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_router #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .HB_REGS(HB_REGS),
    .HB_ID(HB_ID), .HB_CLASS(HB_CLASS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .slotPresent(slotPresent), .slotRdata(slotRdata), .slotReq(slotReq),
    .slotWrite(slotWrite), .slotFunc(slotFunc), .slotReg(slotReg),
    .slotBe(slotBe), .slotWdata(slotWdata), .rspValid(rspValid), .rspRdata(rspRdata)
  );

  function automatic logic [31:0] slotPat(input int k, input logic [5:0] rg, input logic [2:0] fn);
    return {8'hA0 | 8'(k), 2'b00, rg, 5'b00000, fn, 8'h5C};
  endfunction

  always_comb begin
    for (int k = 0; k < NUM_SLOTS; k++) slotRdata[k*32 +: 32] = slotPat(k, slotReg, slotFunc);
  end

  function automatic int lenOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
  endfunction

  function automatic bit accepted(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    int ln = lenOf(sz);
    return (a[ADDR_W-1:32] == '0) && (ln != 0) && (int'(a[1:0]) + ln <= 4) && (a[23:16] == 8'd0);
  endfunction

  function automatic bit slotLive(input logic [4:0] dev);
    return (dev >= 5'd1) && (int'(dev) <= NUM_SLOTS) && PRESENT[int'(dev) - 1];
  endfunction

  function automatic logic [31:0] expRead(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [31:0] v;
    int ln = lenOf(sz);
    logic [4:0] dev = a[15:11];
    if (!accepted(a, sz)) return '1;
    if (dev == 5'd0) v = hbModel[a[7:2]];
    else if (slotLive(dev)) v = slotPat(int'(dev) - 1, a[7:2], a[10:8]);
    else return '1;
    v = v >> (8 * int'(a[1:0]));
    if (ln < 4) v = v & ((32'h1 << (8 * ln)) - 32'h1);
    return v;
  endfunction

  function automatic logic [NUM_SLOTS-1:0] expReq(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [4:0] dev = a[15:11];
    if (!accepted(a, sz) || !slotLive(dev)) return '0;
    return NUM_SLOTS'(1) << (int'(dev) - 1);
  endfunction

  task automatic modelWrite(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int rg = int'(a[7:2]);
    int ln = int'(a[1:0]);
    if (!accepted(a, sz) || a[15:11] != 5'd0) return;
    if (rg >= HB_REGS || rg == 0 || rg == 2) return;
    for (int b = ln; b < ln + lenOf(sz); b++) hbModel[rg][b*8 +: 8] = wd[(b-ln)*8 +: 8];
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    #1;
    obsReq = slotReq; obsBe = slotBe; obsWd = slotWdata; obsFunc = slotFunc; obsReg = slotReg;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    obsRv = rspValid; obsRd = rspRdata;
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [7:0] bus, input logic [4:0] dev,
                                               input logic [2:0] fn, input logic [5:0] rg, input logic [1:0] ln);
    return {{(ADDR_W-24){1'b0}}, bus, dev, fn, rg, ln};
  endfunction

  task automatic readChk(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input string req);
    logic [31:0] e = expRead(a, sz);
    access(1'b0, a, sz, 32'h0);
    chk(obsRv == 1'b1, "R10", 32'(obsRv), 32'h1);
    chk(obsRd == e, req, obsRd, e);
    chk(obsReq == expReq(a, sz), "R8", 32'(obsReq), 32'(expReq(a, sz)));
  endtask

  task automatic writeChk(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] wd, input string req);
    logic [NUM_SLOTS-1:0] er = expReq(a, sz);
    access(1'b1, a, sz, wd);
    modelWrite(a, sz, wd);
    chk(obsRv == 1'b0, "R10", 32'(obsRv), 32'h0);
    chk(obsReq == er, req, 32'(obsReq), 32'(er));
    if (er != '0) begin
      logic [7:0] spread = 8'((32'h1 << lenOf(sz)) - 1) << a[1:0];
      chk(obsBe == spread[3:0], "R8", 32'(obsBe), 32'(spread[3:0]));
      chk(obsWd == (wd << (8 * int'(a[1:0]))), "R8", obsWd, wd << (8 * int'(a[1:0])));
      chk(obsReg == a[7:2] && obsFunc == a[10:8], "R1", {23'd0, obsFunc, obsReg}, {23'd0, a[10:8], a[7:2]});
    end
  endtask

  initial begin
    for (int r = 0; r < 64; r++) hbModel[r] = '0;
    hbModel[0] = HB_ID;
    hbModel[2] = HB_CLASS;

    repeat (3) @(negedge clk);
    chk(rspValid == 1'b0 && rspRdata == 32'h0, "R10", rspRdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rspValid == 1'b0, "R10", 32'(rspValid), 32'h0);

    // Reset contents and fixed identity registers
    readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd5, 2'd0), 2'd2, "R7");
    readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd0, 2'd0), 2'd2, "R7");
    readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd2, 2'd0), 2'd2, "R7");

    // Host-bridge sweep: every register, lane and size code
    for (int rg = 0; rg < HB_REGS + 2; rg++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int sz = 0; sz < 4; sz++) begin
          logic [31:0] wd = {8'(rg), 8'(ln*16 + sz), 8'hC3 ^ 8'(rg), 8'h5A + 8'(ln)};
          writeChk(mkAddr(8'd0, 5'd0, 3'd0, 6'(rg), 2'(ln)), 2'(sz), wd, "R6");
          readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'(rg), 2'd0), 2'd2, "R6");
          readChk(mkAddr(8'd0, 5'd0, 3'(rg % 8), 6'(rg), 2'(ln)), 2'(sz), "R5");
        end
      end
    end

    // R3: crossing and illegal-size reads on host bridge
    readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd4, 2'd3), 2'd1, "R3");
    readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd4, 2'd0), 2'd3, "R3");

    // Slot sweep: present, missing and out-of-range devices
    for (int dev = 0; dev < 8; dev++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int sz = 0; sz < 4; sz++) begin
          logic [5:0] rg = 6'((dev * 7 + ln * 13 + sz) % 64);
          string tag = (dev == 0) ? "R5" : slotLive(5'(dev)) ? "R8" : "R9";
          readChk(mkAddr(8'd0, 5'(dev), 3'(dev), rg, 2'(ln)), 2'(sz), tag);
          if (dev != 0)
            writeChk(mkAddr(8'd0, 5'(dev), 3'(ln), rg, 2'(ln)), 2'(sz), 32'h9E37_79B9 ^ 32'(dev * 256 + ln), tag);
        end
      end
    end

    // R4: other buses read ones and leave register 7 alone
    foreach (hbModel[i]) if (i == 7) hbModel[i] = hbModel[i];
    for (int b = 1; b < 256; b += 63) begin
      writeChk(mkAddr(8'(b), 5'd0, 3'd0, 6'd7, 2'd0), 2'd2, 32'hDEAD_0000 | 32'(b), "R4");
      writeChk(mkAddr(8'(b), 5'd1, 3'd0, 6'd7, 2'd0), 2'd2, 32'h1234_5678, "R4");
      readChk(mkAddr(8'(b), 5'd0, 3'd0, 6'd7, 2'd0), 2'd2, "R4");
      readChk(mkAddr(8'(b), 5'd1, 3'd0, 6'd7, 2'd0), 2'd0, "R4");
      readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd7, 2'd0), 2'd2, "R4");
    end

    // R2: offsets with high bits set
    for (int hb = 32; hb < ADDR_W; hb += 3) begin
      logic [ADDR_W-1:0] a = mkAddr(8'd0, 5'd0, 3'd0, 6'd9, 2'd0) | (ADDR_W'(1) << hb);
      logic [ADDR_W-1:0] s = mkAddr(8'd0, 5'd2, 3'd0, 6'd9, 2'd0) | (ADDR_W'(1) << hb);
      writeChk(a, 2'd2, 32'hFACE_B00C, "R2");
      writeChk(s, 2'd2, 32'hFACE_B00C, "R2");
      readChk(a, 2'd2, "R2");
      readChk(s, 2'd1, "R2");
      readChk(mkAddr(8'd0, 5'd0, 3'd0, 6'd9, 2'd0), 2'd2, "R2");
    end

    // R1: bits 31:24 ignored
    readChk(mkAddr(8'd0, 5'd0, 3'd5, 6'd3, 2'd1) | 40'h00_AB00_0000, 2'd1, "R1");
    readChk(mkAddr(8'd0, 5'd4, 3'd6, 6'd33, 2'd2) | 40'h00_7F00_0000, 2'd1, "R1");

    // R10: idle cycle gives no response
    @(negedge clk);
    chk(rspValid == 1'b0, "R10", 32'(rspValid), 32'h0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule